// File: doc/BRIEF.md
# Tone-Disable Interrupt Collector

This block gathers tone-disable indications from a bank of echo-canceller channels, grouped in pairs, and tells a host processor about them. Each channel supplies a level that is high while a tone disable is present. The block turns every change of that level into an event. Both the appearance and the removal of a tone disable count as events. Events that are not masked place the channel number in a queue and pull an active-low interrupt line.

The host serves the interrupt by reading a queue register. Each read removes the oldest channel number and drives the interrupt line high at once. If more entries remain, the line falls again after a short high gap, so the host sees one falling edge per queued channel. The host then reads a per-channel status register to learn whether the tone disable is still present. Masking works at two levels: one global bit that silences the interrupt line, and one bit per channel in each pair's control register that stops that channel's events from being queued.

The host port is a plain register port with no back-pressure. A read returns its data one cycle later, and a write takes effect at the clock edge that samples it. The event inputs are levels, not a stream, so no valid/ready handshake applies to them.

Top module: `tdint_ctrl`

## Requirements
- R1: A change of `td_in[c]` in either direction is one event for channel c. Both a 0-to-1 and a 1-to-0 change are queued. The input is compared with its value at the previous clock edge, and that value is 0 out of reset.
- R2: An unmasked event is queued at the clock edge that samples the changed input. A read of address 0x40 removes the oldest entry. On the following cycle `reg_rdata` shows it as {3'b000, channel[4:0]}.
- R3: Events from several channels at the same edge are queued in ascending channel order.
- R4: The control register of pair g sits at address g. Its bit 3 masks channel 2g and its bit 4 masks channel 2g+1. An event of a masked channel is not queued.
- R5: Bit 5 of the control register at address 0 is the global mask. While it is 1, `irq_n` is driven high at the next edge and stays high. Queued entries are kept, and the line falls again once the bit is cleared.
- R6: `irq_n` goes low at the edge after the queue becomes non-empty, provided the gap of R7 has passed and the global mask is clear. A read of address 0x40 that removes an entry makes `irq_n` high in the following cycle.
- R7: After each rise, `irq_n` stays high for at least GAP cycles (default 2). It then falls again if entries remain, giving one low pulse per queued channel.
- R8: A read of address 0x40 while the queue is empty returns 0xFF. It removes nothing and leaves `irq_n` high.
- R9: The queue holds DEPTH entries (default 32). Events that find it full are dropped and set a sticky overflow flag, read as bit 0 of address 0x41. Writing 1 to that bit clears the flag.
- R10: Bit 0 of address 0x20+c reads 1 while channel c has a tone disable present, lagging `td_in` by one edge. This bit does not depend on any mask.
- R11: A control register reads back the 8-bit value last written to it, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| td_in | input | 32 | Tone-disable present level, one bit per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `td_in` is already synchronous to `clk`. They also assume that the host never raises `reg_rd` and `reg_wr` in the same cycle, and that each strobe lasts exactly one cycle. The bench meets these assumptions by changing `td_in` and the strobes only on falling edges. It issues each access as a single one-cycle pulse and lets an access finish before the next one starts. It also holds every channel level steady long enough that each change is sampled exactly once.

// File: rtl/tdint_pkg.sv
package tdint_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_QUEUE    = 7'h40;
  localparam logic [ADDR_W-1:0] A_OVERFLOW = 7'h41;
  localparam logic [ADDR_W-1:0] A_STATUS   = 7'h20;
  localparam logic [ADDR_W-1:0] A_STAT_SEL = 7'h60;

  localparam int BIT_MASK_EVEN = 3;
  localparam int BIT_MASK_ODD  = 4;
  localparam int BIT_MASK_ALL  = 5;

  localparam logic [DATA_W-1:0] EMPTY_CODE = 8'hFF;
endpackage

// File: rtl/tdint_capture.sv
module tdint_capture #(
  parameter int CH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] td_in,
  input  logic [CH-1:0] ch_mask,
  output logic [CH-1:0] ev,
  output logic [CH-1:0] td_now
);
  logic [CH-1:0] td_q;

  always_ff @(posedge clk) begin
    if (!rst_n) td_q <= '0;
    else        td_q <= td_in;
  end

  // either edge of the level is an event; masking only gates queueing
  assign ev     = (td_in ^ td_q) & ~ch_mask;
  assign td_now = td_q;
endmodule

// File: rtl/tdint_evfifo.sv
module tdint_evfifo #(
  parameter int CH    = 32,
  parameter int DEPTH = 32,
  localparam int CHW  = $clog2(CH),
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CH-1:0]  push_vec,
  input  logic           pop,
  output logic [CHW-1:0] head,
  output logic [CW-1:0]  cnt,
  output logic           drop
);
  logic [CHW-1:0] mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [PW-1:0]  slot [CH];
  logic [CH-1:0]  acc;
  logic [CW-1:0]  n_acc;

  // ascending channel order: each event takes the slot after all lower ones
  always_comb begin
    int run;
    int space;
    run   = 0;
    space = DEPTH - int'(cnt);
    acc   = '0;
    for (int i = 0; i < CH; i++) begin
      slot[i] = wp + PW'(run);
      if (push_vec[i]) begin
        if (run < space) acc[i] = 1'b1;
        run = run + 1;
      end
    end
    n_acc = (run < space) ? CW'(run) : CW'(space);
  end

  assign drop = |(push_vec & ~acc);
  assign head = mem[rp];

  always_ff @(posedge clk) begin
    for (int i = 0; i < CH; i++) begin
      if (acc[i]) mem[slot[i]] <= CHW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + PW'(n_acc);
      rp  <= rp + PW'(pop);
      cnt <= cnt + n_acc - CW'(pop);
    end
  end
endmodule

// File: rtl/tdint_irq.sv
module tdint_irq #(
  parameter int GAP = 2,
  localparam int GW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic gmask,
  input  logic pop,
  output logic irq_n
);
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n   <= 1'b1;
      gap_cnt <= '0;
    end else if (!irq_n) begin
      if (pop || gmask || !pending) begin
        irq_n   <= 1'b1;
        gap_cnt <= GW'(GAP - 1);
      end
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end else if (pending && !gmask && !pop) begin
      irq_n <= 1'b0;
    end
  end
endmodule

// File: rtl/tdint_ctrl.sv
module tdint_ctrl
  import tdint_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int DEPTH = 32,
  parameter int GAP   = 2,
  localparam int CH   = 2 * NGRP,
  localparam int CHW  = $clog2(CH),
  localparam int GIW  = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     td_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  logic [DATA_W-1:0] ctrl [NGRP];
  logic [CH-1:0]     ch_mask, ev, td_now;
  logic [CHW-1:0]    head;
  logic [CW-1:0]     fifo_cnt;
  logic              drop, ovf, gmask;

  logic is_ctrl, is_stat, is_queue, is_ovf;
  logic pop_fire, rd_empty_fire, ovf_clr;
  logic [GIW-1:0] grp_idx;
  logic [CHW-1:0] stat_ch;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_mask
      assign ch_mask[2*g]   = ctrl[g][BIT_MASK_EVEN];
      assign ch_mask[2*g+1] = ctrl[g][BIT_MASK_ODD];
    end
  endgenerate
  assign gmask = ctrl[0][BIT_MASK_ALL];

  assign grp_idx  = reg_addr[GIW-1:0];
  assign stat_ch  = reg_addr[CHW-1:0];
  assign is_ctrl  = int'(reg_addr) < NGRP;
  assign is_stat  = ((reg_addr & A_STAT_SEL) == A_STATUS) && (int'(stat_ch) < CH);
  assign is_queue = reg_addr == A_QUEUE;
  assign is_ovf   = reg_addr == A_OVERFLOW;

  assign pop_fire      = reg_rd && is_queue && (fifo_cnt != '0);
  assign rd_empty_fire = reg_rd && is_queue && (fifo_cnt == '0);
  assign ovf_clr       = reg_wr && is_ovf && reg_wdata[0];

  tdint_capture #(.CH(CH)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .td_in  (td_in),
    .ch_mask(ch_mask),
    .ev     (ev),
    .td_now (td_now)
  );

  tdint_evfifo #(.CH(CH), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_vec(ev),
    .pop     (pop_fire),
    .head    (head),
    .cnt     (fifo_cnt),
    .drop    (drop)
  );

  tdint_irq #(.GAP(GAP)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(fifo_cnt != '0),
    .gmask  (gmask),
    .pop    (pop_fire),
    .irq_n  (irq_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGRP; i++) ctrl[i] <= '0;
    end else if (reg_wr && is_ctrl) begin
      ctrl[grp_idx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (is_queue)
        reg_rdata <= (fifo_cnt == '0) ? EMPTY_CODE : DATA_W'(head);
      else if (is_ovf)
        reg_rdata <= DATA_W'(ovf);
      else if (is_stat)
        reg_rdata <= DATA_W'(td_now[stat_ch]);
      else if (is_ctrl)
        reg_rdata <= ctrl[grp_idx];
      else
        reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/tdint_chk.sv
module tdint_chk #(
  parameter int DEPTH = 32,
  parameter int GAP   = 2,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_n,
  input logic          pop,
  input logic          gmask,
  input logic          rd_empty,
  input logic          drop,
  input logic          ov,
  input logic          ov_clr,
  input logic [CW-1:0] cnt,
  input logic [7:0]    rdata
);
  AST_HIGH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> irq_n); // R6
  AST_LOW_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> cnt != '0); // R6
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> irq_n); // R5
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |=> rdata == 8'hFF); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH); // R9
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ov); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ov && !ov_clr |=> ov); // R9
  generate
    if (GAP >= 2) begin : g_gap
      AST_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |=> irq_n); // R7
    end
  endgenerate
endmodule

bind tdint_ctrl tdint_chk #(.DEPTH(DEPTH), .GAP(GAP), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_n   (irq_n),
  .pop     (pop_fire),
  .gmask   (gmask),
  .rd_empty(rd_empty_fire),
  .drop    (drop),
  .ov      (ovf),
  .ov_clr  (ovf_clr),
  .cnt     (fifo_cnt),
  .rdata   (reg_rdata)
);

// File: tb/tdint_ctrl_test.sv
module tdint_ctrl_test;
  localparam logic [6:0] A_Q   = 7'h40;
  localparam logic [6:0] A_OV  = 7'h41;
  localparam logic [6:0] A_ST  = 7'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] td = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  tdint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .td_in(td), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; addr = a; wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; addr = a;
    @(negedge clk); reg_rd = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      summary();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    check("R6", "irq after reset", int'(irq_n), 1);
    rreg(A_Q, d);   check("R8", "empty read", int'(d), 255);
    check("R8", "irq after empty read", int'(irq_n), 1);
    rreg(A_OV, d);  check("R9", "overflow after reset", int'(d), 0);
    rreg(7'd3, d);  check("R11", "control after reset", int'(d), 0);

    // single rising events, one channel at a time
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); td[c] = 1'b1;
      idle(2);
      check("R6", "irq low after event", int'(irq_n), 0);
      rreg(A_Q, d);
      check("R2", "queued channel", int'(d), c);
      check("R6", "irq high after read", int'(irq_n), 1);
      rreg(A_ST + 7'(c), d);
      check("R10", "status present", int'(d), 1);
      rreg(A_Q, d);
      check("R8", "queue empty again", int'(d), 255);
    end

    // all channels release together: fills the queue exactly
    @(negedge clk); td = '0;
    idle(2);
    rreg(A_OV, d); check("R9", "exact fill no overflow", int'(d), 0);
    @(negedge clk); td[5] = 1'b1;
    idle(2);
    rreg(A_OV, d); check("R9", "overflow set on drop", int'(d), 1);
    rreg(A_ST + 7'd4, d); check("R10", "status after release", int'(d), 0);
    check("R1", "irq low for releases", int'(irq_n), 0);
    for (int k = 0; k < 32; k++) begin
      rreg(A_Q, d);
      check("R3", "ascending order", int'(d), k);
      check("R6", "irq high after read", int'(irq_n), 1);
      @(negedge clk);
      check("R7", "irq held high in gap", int'(irq_n), 1);
      if (k < 31) begin
        @(negedge clk);
        check("R7", "irq reasserted for remaining", int'(irq_n), 0);
      end
    end
    rreg(A_Q, d);  check("R9", "dropped event absent", int'(d), 255);
    rreg(A_OV, d); check("R9", "overflow sticky", int'(d), 1);
    wreg(A_OV, 8'h01);
    rreg(A_OV, d); check("R9", "overflow cleared", int'(d), 0);
    @(negedge clk); td[5] = 1'b0;
    idle(2);
    rreg(A_Q, d); check("R1", "release event queued", int'(d), 5);

    // mask sweep over every pair and every mask combination
    for (int g = 0; g < 16; g++) begin
      for (int m = 0; m < 4; m++) begin
        wreg(7'(g), 8'(m << 3));
        rreg(7'(g), d); check("R11", "control readback", int'(d), m << 3);
        for (int lvl = 1; lvl >= 0; lvl--) begin
          @(negedge clk); td[2*g] = 1'(lvl); td[2*g+1] = 1'(lvl);
          idle(2);
          rreg(A_ST + 7'(2*g), d); check("R10", "status ignores mask", int'(d), lvl);
          if ((m & 1) == 0) begin
            rreg(A_Q, d); check("R4", "even channel unmasked", int'(d), 2*g);
          end
          if ((m & 2) == 0) begin
            rreg(A_Q, d); check("R4", "odd channel unmasked", int'(d), 2*g+1);
          end
          rreg(A_Q, d); check("R4", "masked events absent", int'(d), 255);
        end
        wreg(7'(g), 8'h00);
      end
    end

    // global mask
    wreg(7'd0, 8'h20);
    @(negedge clk); td[9] = 1'b1;
    idle(4);
    check("R5", "irq held by global mask", int'(irq_n), 1);
    wreg(7'd0, 8'h00);
    @(negedge clk);
    check("R5", "irq after unmask", int'(irq_n), 0);
    rreg(A_Q, d); check("R5", "entry kept under global mask", int'(d), 9);
    check("R6", "irq high after read", int'(irq_n), 1);

    summary();
  end
endmodule